// File: doc/BRIEF.md
# Reset Boot Configuration Selector

This block decides which configuration a chip uses once it leaves reset. While reset is held, it keeps sampling a two-bit boot-mode strap and an eight-bit strap byte taken from the bus data pins. The values present on the last clock edge before reset is released are kept until the next reset. Pin activity after release has no effect.

The stored boot mode then picks one of three configuration sources. The first is a built-in default set. The second is the strap byte, decoded field by field. The third is a 32-bit word supplied by an external serial boot loader. The block drives the decoded fields as steady outputs: boot memory, PLL enable, oscillator bypass, address-latch strobe select, port width code and PLL multiplier. A ready flag tells downstream logic when those fields are final. The ready flag rises on its own in the built-in and strap modes. In serial mode it waits for the loader's completion pulse.

Top module: `boot_cfg_sel`

## Requirements
- R1: Mode strap and strap byte are taken from the last rising clock edge with `rst_n` low. Changing them after reset release alters neither `cfg_ready` nor any configuration output.
- R2: Mode code 00 gives the built-in set whatever the strap byte holds. The built-in set is: boot memory 0 (NAND), PLL on, oscillator bypass 0 (crystal), address-latch select 1, width code 2'b10 (16-bit), multiplier DEF_MULT (10).
- R3: Mode code 01 decodes the strap byte as follows. Bit 0 gives `boot_ext` (1 = external bus, 0 = NAND). Bit 1 gives `pll_en`. Bit 2 gives `osc_bypass`. Bit 3 gives `ale_sel` (1 = address-latch strobe, 0 = transfer-start strobe).
- R4: In mode 01, strap bits 5:4 drive `port_width` directly. They use the serial width encoding: 00 = 32-bit, 01 = 8-bit, 10 and 11 = 16-bit.
- R5: In mode 01, strap bits 7:6 select `pll_mult` as follows: 00 gives 10, 01 gives 15, 10 gives 16 and 11 gives 20.
- R6: Mode code 10 is reserved. It behaves exactly as mode 00.
- R7: In modes 00, 01 and 10, `cfg_ready` is low during reset and rises after the first rising edge with `rst_n` high.
- R8: In mode 11, `cfg_ready` stays low until a rising edge sees `ser_done` high. The word on `ser_word` at that edge is decoded and goes out one cycle later. The decoding is: bits 31:30 width code, bit 29 boot memory, bit 26 address-latch select, bit 25 oscillator bypass, bit 24 PLL enable, bits 21:16 multiplier.
- R9: While `cfg_ready` is low, every configuration output shows the built-in set.
- R10: Once `cfg_ready` is high, it and every configuration output hold steady until the next reset. Later `ser_done` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| mode_pins | input | 2 | Boot-mode strap |
| strap_byte | input | 8 | Strap byte from the bus data pins |
| ser_word | input | 32 | Configuration word from the serial loader |
| ser_done | input | 1 | Loader completion pulse |
| boot_ext | output | 1 | 1 = boot from external bus, 0 = NAND |
| pll_en | output | 1 | PLL enable |
| osc_bypass | output | 1 | 1 = oscillator bypass, 0 = crystal |
| ale_sel | output | 1 | 1 = address-latch strobe, 0 = transfer-start strobe |
| port_width | output | 2 | Port width code |
| pll_mult | output | 6 | PLL multiplier |
| cfg_ready | output | 1 | Configuration final |

## Verification
The bench builds the block with its default parameters: a 6-bit multiplier field and a default multiplier of 10. At that size, all 256 strap bytes can be swept in the strap mode. The same bench also runs the built-in and reserved modes with several strap patterns. In serial mode it covers distinct loader words, a late and a repeated completion pulse, and pin changes after reset release.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
    localparam int MULT_W = 6;

    typedef struct packed {
        logic              boot_ext;
        logic              pll_en;
        logic              osc_bypass;
        logic              ale_sel;
        logic [1:0]        width;
        logic [MULT_W-1:0] mult;
    } cfg_t;

    typedef enum logic [1:0] {
        MODE_BUILTIN  = 2'b00,
        MODE_STRAP    = 2'b01,
        MODE_RESERVED = 2'b10,
        MODE_SERIAL   = 2'b11
    } boot_mode_e;

    function automatic cfg_t builtin_cfg(input logic [MULT_W-1:0] def_mult);
        cfg_t c;
        c.boot_ext   = 1'b0;
        c.pll_en     = 1'b1;
        c.osc_bypass = 1'b0;
        c.ale_sel    = 1'b1;
        c.width      = 2'b10;
        c.mult       = def_mult;
        return c;
    endfunction
endpackage

// File: rtl/boot_strap_decode.sv
module boot_strap_decode
    import boot_cfg_pkg::*;
#(
    parameter int STRAP_W = 8
) (
    input  logic [STRAP_W-1:0] strap,
    output cfg_t               cfg
);
    localparam int SEL_LSB = STRAP_W - 2;

    logic [1:0] mult_sel;
    assign mult_sel = strap[SEL_LSB +: 2];

    always_comb begin
        cfg.boot_ext   = strap[0];
        cfg.pll_en     = strap[1];
        cfg.osc_bypass = strap[2];
        cfg.ale_sel    = strap[3];
        cfg.width      = strap[5:4];
        unique case (mult_sel)
            2'b00:   cfg.mult = MULT_W'(10);
            2'b01:   cfg.mult = MULT_W'(15);
            2'b10:   cfg.mult = MULT_W'(16);
            default: cfg.mult = MULT_W'(20);
        endcase
    end
endmodule

// File: rtl/boot_serial_decode.sv
module boot_serial_decode
    import boot_cfg_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg
);
    localparam int WIDTH_LSB = WORD_W - 2;
    localparam int MEM_BIT   = WORD_W - 3;
    localparam int ALE_BIT   = WORD_W - 6;
    localparam int OSC_BIT   = WORD_W - 7;
    localparam int PLL_BIT   = WORD_W - 8;
    localparam int MULT_LSB  = WORD_W - 16;

    always_comb begin
        cfg.width      = word[WIDTH_LSB +: 2];
        cfg.boot_ext   = word[MEM_BIT];
        cfg.ale_sel    = word[ALE_BIT];
        cfg.osc_bypass = word[OSC_BIT];
        cfg.pll_en     = word[PLL_BIT];
        cfg.mult       = word[MULT_LSB +: MULT_W];
    end
endmodule

// File: rtl/boot_cfg_sel.sv
module boot_cfg_sel
    import boot_cfg_pkg::*;
#(
    parameter int STRAP_W  = 8,
    parameter int WORD_W   = 32,
    parameter int DEF_MULT = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_pins,
    input  logic [STRAP_W-1:0]  strap_byte,
    input  logic [WORD_W-1:0]   ser_word,
    input  logic                ser_done,
    output logic                boot_ext,
    output logic                pll_en,
    output logic                osc_bypass,
    output logic                ale_sel,
    output logic [1:0]          port_width,
    output logic [MULT_W-1:0]   pll_mult,
    output logic                cfg_ready
);
    localparam cfg_t DEF_CFG = builtin_cfg(MULT_W'(DEF_MULT));

    typedef struct packed {
        boot_mode_e          mode;
        logic [STRAP_W-1:0]  strap;
        logic                ready;
        cfg_t                cfg;
    } state_t;

    state_t st_d, st_q;
    cfg_t   strap_cfg, serial_cfg;

    boot_strap_decode #(.STRAP_W(STRAP_W)) u_strap (
        .strap (st_q.strap),
        .cfg   (strap_cfg)
    );

    boot_serial_decode #(.WORD_W(WORD_W)) u_serial (
        .word  (ser_word),
        .cfg   (serial_cfg)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode  = boot_mode_e'(mode_pins);
            st_d.strap = strap_byte;
            st_d.ready = 1'b0;
            st_d.cfg   = DEF_CFG;
        end else if (!st_q.ready) begin
            unique case (st_q.mode)
                MODE_STRAP: begin
                    st_d.ready = 1'b1;
                    st_d.cfg   = strap_cfg;
                end
                MODE_SERIAL: begin
                    if (ser_done) begin
                        st_d.ready = 1'b1;
                        st_d.cfg   = serial_cfg;
                    end
                end
                default: begin
                    st_d.ready = 1'b1;
                    st_d.cfg   = DEF_CFG;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign boot_ext   = st_q.cfg.boot_ext;
    assign pll_en     = st_q.cfg.pll_en;
    assign osc_bypass = st_q.cfg.osc_bypass;
    assign ale_sel    = st_q.cfg.ale_sel;
    assign port_width = st_q.cfg.width;
    assign pll_mult   = st_q.cfg.mult;
    assign cfg_ready  = st_q.ready;

    // R10: ready, once set, stays set until reset
    a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> cfg_ready);

    // R10: outputs frozen once ready
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> $stable({boot_ext, pll_en, osc_bypass, ale_sel, port_width, pll_mult}));

    // R9: built-in set shown while not ready
    a_r9_default_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> ({boot_ext, pll_en, osc_bypass, ale_sel, port_width, pll_mult} == DEF_CFG));

    // R7: non-serial modes go ready after one cycle
    a_r7_prompt_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ready && st_q.mode != MODE_SERIAL) |=> cfg_ready);

    // R8: serial mode waits for the loader
    a_r8_serial_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ready && st_q.mode == MODE_SERIAL && !ser_done) |=> !cfg_ready);
endmodule

// File: tb/boot_cfg_sel_bench.sv
module boot_cfg_sel_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_pins = 2'b00;
    logic [7:0]  strap_byte = 8'h00;
    logic [31:0] ser_word = 32'h0;
    logic        ser_done = 1'b0;
    logic        boot_ext, pll_en, osc_bypass, ale_sel, cfg_ready;
    logic [1:0]  port_width;
    logic [5:0]  pll_mult;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_cfg_sel u_boot_cfg_sel (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .strap_byte(strap_byte),
        .ser_word(ser_word), .ser_done(ser_done), .boot_ext(boot_ext), .pll_en(pll_en),
        .osc_bypass(osc_bypass), .ale_sel(ale_sel), .port_width(port_width),
        .pll_mult(pll_mult), .cfg_ready(cfg_ready)
    );

    localparam logic [11:0] BUILTIN = {1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 6'd10};

    function automatic logic [11:0] got();
        return {boot_ext, pll_en, osc_bypass, ale_sel, port_width, pll_mult};
    endfunction

    function automatic logic [11:0] exp_strap(input logic [7:0] s);
        logic [5:0] m;
        case (s[7:6])
            2'b00: m = 6'd10;
            2'b01: m = 6'd15;
            2'b10: m = 6'd16;
            default: m = 6'd20;
        endcase
        return {s[0], s[1], s[2], s[3], s[5:4], m};
    endfunction

    function automatic logic [11:0] exp_word(input logic [31:0] w);
        return {w[29], w[24], w[25], w[26], w[31:30], w[21:16]};
    endfunction

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // hold reset with given straps, release on a negedge; ready not yet set
    task automatic reset_with(input logic [1:0] m, input logic [7:0] s);
        @(negedge clk);
        rst_n = 1'b0; mode_pins = m; strap_byte = s; ser_done = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset state", {cfg_ready, got()}, {1'b0, BUILTIN});
        rst_n = 1'b1;
        mode_pins = ~m; strap_byte = ~s;   // R1: post-release changes ignored
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] words [4];
        words[0] = 32'hE5AB_0000; words[1] = 32'h0014_FFFF;
        words[2] = 32'h7F3F_1234; words[3] = 32'h2100_0000;

        // R2: built-in mode, strap byte ignored
        foreach (words[i]) begin
            reset_with(2'b00, words[i][7:0] ^ 8'hA5);
            @(negedge clk);
            check("R2 builtin", {cfg_ready, got()}, {1'b1, BUILTIN});
            repeat (2) @(negedge clk);
            check("R1 pins ignored after release", {cfg_ready, got()}, {1'b1, BUILTIN});
        end

        // R6: reserved mode falls back to built-in
        for (int s = 0; s < 256; s += 51) begin
            reset_with(2'b10, 8'(s));
            @(negedge clk);
            check("R6 reserved", {cfg_ready, got()}, {1'b1, BUILTIN});
        end

        // R3 R4 R5 R7: full strap sweep
        for (int s = 0; s < 256; s++) begin
            reset_with(2'b01, 8'(s));
            check("R7 ready low at release", {12'b0, cfg_ready}, 13'd0);
            @(negedge clk);
            check("R3 R4 R5 strap decode", {cfg_ready, got()}, {1'b1, exp_strap(8'(s))});
            @(negedge clk);
            check("R1 strap held", {cfg_ready, got()}, {1'b1, exp_strap(8'(s))});
        end

        // R8 R10: serial loader
        foreach (words[i]) begin
            reset_with(2'b11, 8'hFF);
            ser_word = ~words[i];
            repeat (i + 3) @(negedge clk);
            check("R8 waiting for loader", {cfg_ready, got()}, {1'b0, BUILTIN});
            ser_word = words[i]; ser_done = 1'b1;
            @(negedge clk);
            ser_done = 1'b0; ser_word = 32'h5A5A_5A5A;
            check("R8 serial decode", {cfg_ready, got()}, {1'b1, exp_word(words[i])});
            @(negedge clk);
            ser_done = 1'b1;
            @(negedge clk);
            ser_done = 1'b0;
            check("R10 later done ignored", {cfg_ready, got()}, {1'b1, exp_word(words[i])});
        end

        // R8: done asserted on very first cycle after release
        reset_with(2'b11, 8'h00);
        ser_word = 32'h9C0B_0000; ser_done = 1'b1;
        @(negedge clk);
        ser_done = 1'b0;
        check("R8 immediate done", {cfg_ready, got()}, {1'b1, exp_word(32'h9C0B_0000)});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule